// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block parks every output clock group of a clock synthesizer low and then shuts off its oscillators when an asynchronous, active-low power-down request arrives. When the request is released, it restarts the oscillators in order and keeps the outputs parked until they can be released. The request first passes through a two-flop synchronizer. The group stop is timed to a falling edge of the internal CPU clock, so no output is cut short. The oscillators stay on until every group has been seen low, because some groups, the reference outputs among them, take more than one cycle to settle.

The restart is released by the first of two events. One is a lock indication from the PLL. The other is a cycle timeout counted on the sequencer clock, which is derived from the reference frequency and a latency budget so that power-up stays within 3 ms. A new request that arrives during the restart sends the sequencer back to the stopping path, and no output is released. The sequencer clock `clk_i` is the always-running reference. `lock_i` is taken as synchronous to it. The CPU clock level and the group clock levels are sampled through two-flop synchronizers.

Top module: `pd_clk_sequencer`

## Requirements
- R1: After reset, every bit of `grp_stop_o` is 0 and both `vco_en_o` and `xtal_en_o` are 1.
- R2: `pd_req_ni` is synchronized by two flops. A level change driven just after a clock edge acts on the state at the third following edge. On release from power-down, `xtal_en_o` stays 0 after two edges and becomes 1 after the third.
- R3: With a synchronized request pending, no group stops while `cpu_clk_i` stays high. Every bit of `grp_stop_o` becomes 1 together, at the third edge after `cpu_clk_i` falls.
- R4: With the groups stopped, `vco_en_o` stays 1 while any bit of `grp_clk_i` is still sampled high. It falls at the third edge after the last bit goes low.
- R5: In power-down, `vco_en_o` and `xtal_en_o` are both 0 and all groups stay stopped for as long as the request is held.
- R6: On release, the crystal is enabled one cycle before the VCO: `xtal_en_o`=1 and `vco_en_o`=0 for exactly one cycle. The groups stay stopped throughout.
- R7: While waiting for the restart, `lock_i`=1 releases every group at the next edge.
- R8: Without lock, the groups are released exactly TMO_CYC = REF_KHZ*LIMIT_US/1000 cycles after `vco_en_o` returns to 1.
- R9: A synchronized request during the restart wins over `lock_i` in the same cycle. The groups stay stopped and the oscillators go off again once all groups are sampled low.
- R10: Releasing the request after it has reached the stopping path does not abort the sequence. The block still waits for the CPU falling edge, stops the groups, shuts off the oscillators and then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock for the sequencer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_i | input | 1 | Internal CPU clock level; its falling edge times the stop |
| grp_clk_i | input | NUM_GRP | Observed level of each gated output group |
| lock_i | input | 1 | PLL/oscillator stable indication |
| grp_stop_o | output | NUM_GRP | 1 = hold that output group low |
| vco_en_o | output | 1 | VCO enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |

## Verification
The bench sets REF_KHZ=1000 and LIMIT_US=20, so the restart timeout is 20 cycles. This brings the timeout exit, and its exact cycle count, within a short directed run instead of the roughly 41,000 cycles of the default. NUM_GRP=4 keeps the group vector small. It still lets one lagging group hold off the oscillator shutdown while the others are already low.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOPPING,
    ST_WAIT_REF_LOW,
    ST_OSC_OFF,
    ST_OSC_START,
    ST_WAIT_LOCK
  } seq_state_e;
endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int unsigned LIMIT = 41522
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // R8: count never passes the timeout
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_n_i,
  input  logic cpu_fall_i,
  input  logic all_low_i,
  input  logic lock_i,
  input  logic expire_i,
  output logic stop_o,
  output logic vco_en_o,
  output logic xtal_en_o,
  output logic tmr_run_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:          if (!pd_n_i) state_d = ST_STOPPING;
      ST_STOPPING:     if (cpu_fall_i) state_d = ST_WAIT_REF_LOW;
      ST_WAIT_REF_LOW: if (all_low_i) state_d = ST_OSC_OFF;
      ST_OSC_OFF:      if (pd_n_i) state_d = ST_OSC_START;
      ST_OSC_START:    state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: begin
        if (!pd_n_i)                state_d = ST_WAIT_REF_LOW;
        else if (lock_i || expire_i) state_d = ST_RUN;
      end
      default:         state_d = ST_WAIT_REF_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign stop_o    = !(state_q == ST_RUN || state_q == ST_STOPPING);
  assign xtal_en_o = (state_q != ST_OSC_OFF);
  assign vco_en_o  = !(state_q == ST_OSC_OFF || state_q == ST_OSC_START);
  assign tmr_run_o = (state_q == ST_WAIT_LOCK);

  // R5: oscillators off only with groups parked
  a_r5_off_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vco_en_o |-> stop_o);
  // R6: vco comes up only after the crystal is running
  a_r6_xtal_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vco_en_o) |-> $past(xtal_en_o) && xtal_en_o);
  // R9: no release while a request is pending
  a_r9_no_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_o) |-> $past(pd_n_i));
  // R7: lock ends the restart on the next edge
  a_r7_lock_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_run_o && pd_n_i && lock_i) |=> !stop_o);
endmodule

// File: rtl/pd_clk_sequencer.sv
module pd_clk_sequencer #(
  parameter int unsigned NUM_GRP  = 7,
  parameter int unsigned REF_KHZ  = 14318,
  parameter int unsigned LIMIT_US = 2900
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_req_ni,
  input  logic               cpu_clk_i,
  input  logic [NUM_GRP-1:0] grp_clk_i,
  input  logic               lock_i,
  output logic [NUM_GRP-1:0] grp_stop_o,
  output logic               vco_en_o,
  output logic               xtal_en_o
);
  localparam int unsigned TMO_CYC = REF_KHZ * LIMIT_US / 1000;

  logic pd_n_s, cpu_s, cpu_prev_q, cpu_fall;
  logic [NUM_GRP-1:0] grp_s;
  logic all_low, stop, tmr_run, expire;

  pdseq_sync #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pd_req_ni), .q_o(pd_n_s));

  pdseq_sync #(.W(1), .RST_VAL(1'b0)) u_cpu_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cpu_clk_i), .q_o(cpu_s));

  pdseq_sync #(.W(NUM_GRP), .RST_VAL('0)) u_grp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(grp_clk_i), .q_o(grp_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_prev_q <= 1'b0;
    else         cpu_prev_q <= cpu_s;
  end

  assign cpu_fall = cpu_prev_q & ~cpu_s;
  assign all_low  = ~|grp_s;

  pdseq_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(tmr_run), .expire_o(expire));

  pdseq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_n_i(pd_n_s), .cpu_fall_i(cpu_fall),
    .all_low_i(all_low), .lock_i(lock_i), .expire_i(expire),
    .stop_o(stop), .vco_en_o(vco_en_o), .xtal_en_o(xtal_en_o),
    .tmr_run_o(tmr_run));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_stop
    assign grp_stop_o[g] = stop;
  end

  // R3: groups park only on a synchronized cpu falling edge
  a_r3_stop_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grp_stop_o[0]) |-> $past(cpu_fall) || $past(tmr_run));
  // R4: vco drops only once every group is seen low
  a_r4_off_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vco_en_o) |-> $past(all_low));
endmodule

// File: tb/sim_pd_clk_sequencer.sv
module sim_pd_clk_sequencer;
  localparam int NG = 4;
  localparam int T  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, cpu = 1'b1, lock = 1'b0;
  logic [NG-1:0] grp = '1;
  logic [NG-1:0] stop;
  logic vco, xtal;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pd_clk_sequencer #(.NUM_GRP(NG), .REF_KHZ(1000), .LIMIT_US(20)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_ni(pd_n), .cpu_clk_i(cpu),
    .grp_clk_i(grp), .lock_i(lock), .grp_stop_o(stop),
    .vco_en_o(vco), .xtal_en_o(xtal));

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // drives from RUN to oscillators off
  task automatic power_down();
    cpu = 1'b1; tick(3);
    pd_n = 1'b0; tick(4);
    cpu = 1'b0; tick(3);
    grp = '0; tick(3);
  endtask

  task automatic release_pd();
    pd_n = 1'b1; tick(4);
  endtask

  task automatic t_reset();
    chk("R1 stop", stop, 0);
    chk("R1 vco", vco, 1);
    chk("R1 xtal", xtal, 1);
  endtask

  task automatic t_stop_sequence();
    cpu = 1'b1; tick(2);
    pd_n = 1'b0; tick(8);
    chk("R3 no stop while cpu high", stop, 0);
    cpu = 1'b0; tick(2);
    chk("R3 stop not yet", stop, 0);
    tick(1);
    chk("R3 all groups stop", stop, 4'hf);
    tick(6);
    chk("R4 vco on while groups high", vco, 1);
    grp = 4'b0001; tick(6);
    chk("R4 vco on while one group lags", vco, 1);
    grp = '0; tick(2);
    chk("R4 vco before low sync", vco, 1);
    tick(1);
    chk("R4 vco off", vco, 0);
    chk("R5 xtal off", xtal, 0);
    tick(10);
    chk("R5 still off", {stop, vco, xtal}, {4'hf, 2'b00});
  endtask

  task automatic t_release_timeout();
    pd_n = 1'b1; tick(2);
    chk("R2 xtal after 2 edges", xtal, 0);
    tick(1);
    chk("R6 xtal first", {xtal, vco}, 2'b10);
    chk("R6 held", stop, 4'hf);
    tick(1);
    chk("R6 vco on", vco, 1);
    chk("R6 held", stop, 4'hf);
    tick(T - 1);
    chk("R8 held before timeout", stop, 4'hf);
    tick(1);
    chk("R8 released at timeout", stop, 0);
    grp = '1;
  endtask

  task automatic t_lock();
    power_down();
    chk("R5 off", {vco, xtal}, 2'b00);
    release_pd();
    tick(3);
    chk("R7 held", stop, 4'hf);
    lock = 1'b1; tick(1);
    chk("R7 lock releases", stop, 0);
    lock = 1'b0;
    grp = '1;
  endtask

  task automatic t_rerequest();
    power_down();
    release_pd();
    tick(2);
    pd_n = 1'b0; tick(2);
    chk("R9 held during sync", stop, 4'hf);
    lock = 1'b1; tick(1);
    chk("R9 request beats lock", stop, 4'hf);
    chk("R9 vco still on", vco, 1);
    tick(1);
    chk("R9 oscillators off", {vco, xtal}, 2'b00);
    chk("R9 held", stop, 4'hf);
    lock = 1'b0;
    release_pd();
    tick(T);
    chk("R9 restart completes", stop, 0);
    grp = '1;
  endtask

  task automatic t_no_abort();
    cpu = 1'b1; tick(3);
    pd_n = 1'b0; tick(4);
    pd_n = 1'b1; tick(4);
    chk("R10 still waiting", {stop, vco}, {4'h0, 1'b1});
    cpu = 1'b0; tick(3);
    chk("R10 stop after fall", stop, 4'hf);
    grp = '0; tick(3);
    chk("R10 oscillators off", vco, 0);
    tick(1);
    chk("R10 restart xtal", {xtal, vco}, 2'b10);
    tick(1);
    chk("R10 restart vco", vco, 1);
    tick(T);
    chk("R10 released", stop, 0);
    grp = '1;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_stop_sequence();
    t_release_timeout();
    t_lock();
    t_rerequest();
    t_no_abort();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule